// File: doc/BRIEF.md
# Memory-to-Memory Multicycle Processor Core

This block is a small processor core with no register file. Instructions and data share one synchronous single-port memory of 32-bit words. Every operand is read from memory and every result is written back to memory. Each 32-bit instruction word holds a 3-bit opcode, an immediate-select bit and two 14-bit fields, A and B. A multicycle state machine moves through a fixed order of states: fetch, decode, read operand A, read operand B, an optional second dependent read, then execute. The execute state performs the single write-back and updates the program counter.

The memory port drives one address in every cycle. Read data comes back one clock later. Writes take effect at the clock edge of the execute state. The core covers unsigned arithmetic, bitwise and compare operations. It also covers copies, including a load-indirect copy and a store-indirect copy, a branch on zero to a target held in memory, and an unconditional jump. Addresses are 14 bits wide, and every pointer taken from memory is truncated to its low 14 bits.

Top module: `mm_core`

## Requirements
- R1: While the asynchronous active-low reset `rst_ni` is asserted, the program counter is cleared to 0. In the first cycle after reset is released, the memory address is 0 and write enable is low.
- R2: Instruction word layout:
  - opcode in bits [31:29]
  - immediate-select in bit 28
  - A in bits [27:14]
  - B in bits [13:0]

  The second operand is mem[B] when bit 28 is 0, and B zero-extended when bit 28 is 1. Opcode 0 writes (mem[A] + second) mod 2^32 to mem[A].
- R3: Opcode 1 writes the bitwise NAND of mem[A] and the second operand to mem[A].
- R4: Opcode 7 writes the low 32 bits of the unsigned product of mem[A] and the second operand to mem[A].
- R5: Opcode 2 uses the second operand as a shift amount s.
  - If s < 32, it writes mem[A] shifted right logically by s.
  - Otherwise it writes mem[A] shifted left by s-32.
  - When s-32 is 32 or more, the result is 0.
- R6: Opcode 3 writes 1 to mem[A] when mem[A] is below the second operand (unsigned compare), and 0 otherwise.
- R7: Opcode 4 writes the second operand to mem[A].
- R8: Opcode 5 with bit 28 = 0 writes mem[P] to mem[A], where P is the low 14 bits of mem[B]. The instruction takes 6 cycles instead of 5.
- R9: Opcode 5 with bit 28 = 1 writes mem[B] to address Q, where Q is the low 14 bits of mem[A]. mem[A] itself is left unchanged unless Q equals A.
- R10: Opcode 6 with bit 28 = 0 never writes memory.
  - If mem[B] is zero, it sets the PC to the low 14 bits of mem[A].
  - Otherwise it sets the PC to PC+1.
- R11: Opcode 6 with bit 28 = 1 never writes memory. It sets the PC to the low 14 bits of mem[A] + B.
- R12: Every instruction other than opcode 6 advances the PC by 1 modulo 2^14. Each instruction issues at most one write, and only in its last cycle. The PC changes only in that last cycle.
- R13: The fetch of the next instruction follows the last cycle of the current one directly. An instruction takes 5 cycles from fetch to fetch, or 6 cycles for the load-indirect copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 14 | Word address presented to the memory every cycle |
| mem_wdata_o | output | 32 | Write data, valid while mem_we_o is high |
| mem_we_o | output | 1 | Write enable, sampled by the memory at the clock edge |
| mem_rdata_i | input | 32 | Read data for the address presented one cycle earlier |

## Verification
The bound checker watches the sequencing on every cycle:
- the address and write state right after reset
- that writes happen only in the execute state, and never twice in a row
- that branches never write
- that the PC holds between instructions and steps by one after non-branch ones
- that the execute state always returns to fetch
- that the load-indirect copy takes its extra read

The checker cannot see whether the right value reached the right address. That comes only from the bench scenarios. They sweep operand pairs through each arithmetic opcode in both operand modes, and sweep the shift amount across the right, left and zero-result ranges. They also exercise pointer truncation in both indirect copies, taken and untaken branches, jump-target wrap, and PC wrap from the last address back to 0.

// File: rtl/mm_pkg.sv
package mm_pkg;

    localparam int ADDR_W  = 14;
    localparam int OP_W    = 3;
    localparam int DATA_W  = 2 * ADDR_W + OP_W + 1;
    localparam int IMM_BIT = 2 * ADDR_W;
    localparam int SH_W    = $clog2(DATA_W);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_NAND = 3'd1,
        OP_SHF  = 3'd2,
        OP_LT   = 3'd3,
        OP_CPY  = 3'd4,
        OP_IND  = 3'd5,
        OP_BRZ  = 3'd6,
        OP_MUL  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_FETCH = 3'd0,
        ST_DEC   = 3'd1,
        ST_RDA   = 3'd2,
        ST_RDB   = 3'd3,
        ST_RDI   = 3'd4,
        ST_EXE   = 3'd5
    } state_e;

    typedef struct packed {
        state_e st;
        addr_t  pc;
        word_t  ir;
        word_t  opa;
        word_t  opb;
    } core_s;

    function automatic op_e f_op(word_t w);
        return op_e'(w[DATA_W-1 -: OP_W]);
    endfunction

    function automatic logic f_imm(word_t w);
        return w[IMM_BIT];
    endfunction

    function automatic addr_t f_fa(word_t w);
        return w[2*ADDR_W-1:ADDR_W];
    endfunction

    function automatic addr_t f_fb(word_t w);
        return w[ADDR_W-1:0];
    endfunction

endpackage

// File: rtl/mm_alu.sv
module mm_alu
    import mm_pkg::*;
(
    input  op_e   op_i,
    input  word_t a_i,
    input  word_t b_i,
    output word_t res_o
);

    word_t sh_left_amt;
    word_t res;

    always_comb begin
        sh_left_amt = b_i - word_t'(DATA_W);
        res         = b_i;
        case (op_i)
            OP_ADD:  res = a_i + b_i;
            OP_NAND: res = ~(a_i & b_i);
            OP_MUL:  res = a_i * b_i;
            OP_LT:   res = {{(DATA_W-1){1'b0}}, (a_i < b_i)};
            OP_SHF: begin
                if (b_i < word_t'(DATA_W)) begin
                    res = a_i >> b_i[SH_W-1:0];
                end else if (sh_left_amt < word_t'(DATA_W)) begin
                    res = a_i << sh_left_amt[SH_W-1:0];
                end else begin
                    res = '0;
                end
            end
            default: res = b_i;
        endcase
    end

    assign res_o = res;

endmodule

// File: rtl/mm_pcgen.sv
module mm_pcgen
    import mm_pkg::*;
(
    input  op_e   op_i,
    input  logic  imm_i,
    input  addr_t pc_i,
    input  word_t opa_i,
    input  word_t opb_i,
    input  addr_t fb_i,
    output addr_t pc_next_o
);

    addr_t seq_pc;
    addr_t tgt_mem;
    addr_t tgt_jmp;

    always_comb begin
        seq_pc  = pc_i + addr_t'(1);
        tgt_mem = opa_i[ADDR_W-1:0];
        tgt_jmp = tgt_mem + fb_i;
        pc_next_o = seq_pc;
        if (op_i == OP_BRZ) begin
            if (imm_i) begin
                pc_next_o = tgt_jmp;
            end else if (opb_i == '0) begin
                pc_next_o = tgt_mem;
            end
        end
    end

endmodule

// File: rtl/mm_core.sv
module mm_core
    import mm_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);

    core_s q, d;

    op_e    op;
    logic   imm;
    addr_t  fa;
    addr_t  fb;
    word_t  alu_b;
    word_t  alu_res;
    addr_t  pc_next;
    addr_t  addr_d;
    logic   we_d;

    state_e st_q;
    addr_t  pc_q;

    assign op   = f_op(q.ir);
    assign imm  = f_imm(q.ir);
    assign fa   = f_fa(q.ir);
    assign fb   = f_fb(q.ir);
    assign st_q = q.st;
    assign pc_q = q.pc;

    // immediate form uses the B field itself, except the store-indirect copy
    assign alu_b = (imm && op != OP_IND) ? {{(DATA_W-ADDR_W){1'b0}}, fb} : q.opb;

    mm_alu u_alu (
        .op_i  (op),
        .a_i   (q.opa),
        .b_i   (alu_b),
        .res_o (alu_res)
    );

    mm_pcgen u_pcgen (
        .op_i      (op),
        .imm_i     (imm),
        .pc_i      (q.pc),
        .opa_i     (q.opa),
        .opb_i     (q.opb),
        .fb_i      (fb),
        .pc_next_o (pc_next)
    );

    always_comb begin
        d      = q;
        addr_d = q.pc;
        we_d   = 1'b0;
        case (q.st)
            ST_FETCH: begin
                addr_d = q.pc;
                d.st   = ST_DEC;
            end
            ST_DEC: begin
                d.ir   = mem_rdata_i;
                addr_d = f_fa(mem_rdata_i);
                d.st   = ST_RDA;
            end
            ST_RDA: begin
                d.opa  = mem_rdata_i;
                addr_d = fb;
                d.st   = ST_RDB;
            end
            ST_RDB: begin
                d.opb = mem_rdata_i;
                if (op == OP_IND && !imm) begin
                    addr_d = mem_rdata_i[ADDR_W-1:0];
                    d.st   = ST_RDI;
                end else begin
                    d.st   = ST_EXE;
                end
            end
            ST_RDI: begin
                d.opb = mem_rdata_i;
                d.st  = ST_EXE;
            end
            ST_EXE: begin
                d.pc = pc_next;
                d.st = ST_FETCH;
                if (op != OP_BRZ) begin
                    we_d   = 1'b1;
                    addr_d = (op == OP_IND && imm) ? q.opa[ADDR_W-1:0] : fa;
                end
            end
            default: d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_addr_o  = addr_d;
    assign mem_we_o    = we_d;
    assign mem_wdata_o = alu_res;

endmodule

// File: rtl/mm_core_chk.sv
module mm_core_chk
    import mm_pkg::*;
(
    input logic   clk_i,
    input logic   rst_ni,
    input logic   we,
    input addr_t  addr,
    input state_e st,
    input addr_t  pc,
    input op_e    op,
    input logic   imm
);

    // R1: first cycle out of reset reads address 0 without writing
    p_first_fetch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rst_ni) |-> (addr == '0 && !we));

    // R12: a write only in the last cycle of an instruction
    p_write_in_exe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we |-> st == ST_EXE);

    // R12: never two writes back to back
    p_single_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we |=> !we);

    // R10 / R11: branches and jumps leave memory untouched
    p_branch_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == ST_EXE && op == OP_BRZ) |-> !we);

    // R12: non-branch instructions step the PC by one
    p_pc_step_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == ST_EXE && op != OP_BRZ) |=> pc == addr_t'($past(pc) + addr_t'(1)));

    // R12: PC frozen outside the last cycle
    p_pc_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st != ST_EXE) |=> $stable(pc));

    // R13: the execute state hands over to fetch
    p_fetch_follows_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == ST_EXE) |=> st == ST_FETCH);

    // R8: load-indirect copy takes the extra dependent read
    p_indirect_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == ST_RDB && op == OP_IND && !imm) |=> st == ST_RDI);

endmodule

bind mm_core mm_core_chk u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we     (mem_we_o),
    .addr   (mem_addr_o),
    .st     (st_q),
    .pc     (pc_q),
    .op     (op),
    .imm    (imm)
);

// File: tb/tb_mm_core.sv
module tb_mm_core;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [13:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic        mem_we_o;
    logic [31:0] mem_rdata_i = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int wr_cnt  = 0;
    bit done    = 0;

    logic [31:0] mem [int];

    always #5 clk_i = ~clk_i;

    mm_core dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_we_o    (mem_we_o),
        .mem_rdata_i (mem_rdata_i)
    );

    function automatic logic [31:0] rd(input int a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk_i) begin
        if (mem_we_o) begin
            mem[int'(mem_addr_o)] = mem_wdata_o;
            wr_cnt = wr_cnt + 1;
        end
        mem_rdata_i <= rd(int'(mem_addr_o));
    end

    function automatic logic [31:0] enc(input int op, input int imm, input int a, input int b);
        return {op[2:0], imm[0], a[13:0], b[13:0]};
    endfunction

    function automatic logic [31:0] model(input int op, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p;
        case (op)
            0: return a + b;
            1: return ~(a & b);
            2: begin
                if (b < 32) return a >> b;
                if (b - 32 < 32) return a << (b - 32);
                return 32'h0;
            end
            3: return (a < b) ? 32'd1 : 32'd0;
            7: begin
                p = {32'h0, a} * {32'h0, b};
                return p[31:0];
            end
            default: return b;
        endcase
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            3: return "R6";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // R1 and R12/R13 checks around one program run
    task automatic run_prog(input int cycles, input logic [13:0] exp_pc, input int exp_wr, input string req);
        rst_ni = 1'b0;
        @(negedge clk_i);
        @(negedge clk_i);
        wr_cnt = 0;
        rst_ni = 1'b1;
        #1;
        chk("R1", "address after reset", {18'h0, mem_addr_o}, 32'h0);
        chk("R1", "write enable after reset", {31'h0, mem_we_o}, 32'h0);
        @(negedge clk_i);
        repeat (cycles - 1) @(negedge clk_i);
        chk(req, "next fetch address", {18'h0, mem_addr_o}, {18'h0, exp_pc});
        chk(req, "write count", wr_cnt, exp_wr);
        rst_ni = 1'b0;
    endtask

    initial begin
        logic [31:0] vals [8];
        int ops [4];
        logic [31:0] second;
        vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'h12345678; vals[3] = 32'd31;
        vals[4] = 32'd32;       vals[5] = 32'h3FFF;     vals[6] = 32'h80000000; vals[7] = 32'hFFFFFFFF;
        ops[0] = 0; ops[1] = 1; ops[2] = 3; ops[3] = 7;

        // R2 R3 R4 R6 sweeps, both operand modes
        for (int oi = 0; oi < 4; oi++) begin
            for (int ia = 0; ia < 8; ia++) begin
                for (int ib = 0; ib < 8; ib++) begin
                    for (int im = 0; im < 2; im++) begin
                        mem.delete();
                        mem[100] = vals[ia];
                        if (im == 0) begin
                            mem[200] = vals[ib];
                            mem[0] = enc(ops[oi], 0, 100, 200);
                            second = vals[ib];
                        end else begin
                            mem[0] = enc(ops[oi], 1, 100, int'(vals[ib][13:0]));
                            second = {18'h0, vals[ib][13:0]};
                        end
                        run_prog(5, 14'd1, 1, "R12");
                        chk(req_of(ops[oi]), "alu result", rd(100), model(ops[oi], vals[ia], second));
                    end
                end
            end
        end

        // R5 shift amount sweep across right, left and zero ranges
        for (int s = 0; s < 71; s++) begin
            for (int im = 0; im < 2; im++) begin
                for (int va = 0; va < 2; va++) begin
                    mem.delete();
                    mem[100] = (va == 0) ? 32'h80000001 : 32'hDEADBEEF;
                    if (im == 0) begin
                        mem[200] = s;
                        mem[0] = enc(2, 0, 100, 200);
                    end else begin
                        mem[0] = enc(2, 1, 100, s);
                    end
                    run_prog(5, 14'd1, 1, "R12");
                    chk("R5", "shift result", rd(100),
                        model(2, (va == 0) ? 32'h80000001 : 32'hDEADBEEF, s));
                end
            end
        end
        mem.delete();
        mem[100] = 32'hDEADBEEF; mem[200] = 32'hFFFFFFFF; mem[0] = enc(2, 0, 100, 200);
        run_prog(5, 14'd1, 1, "R12");
        chk("R5", "huge shift gives zero", rd(100), 32'h0);

        // R7 copy
        mem.delete();
        mem[100] = 32'h11111111; mem[200] = 32'hCAFEF00D; mem[0] = enc(4, 0, 100, 200);
        run_prog(5, 14'd1, 1, "R12");
        chk("R7", "copy from memory", rd(100), 32'hCAFEF00D);
        mem.delete();
        mem[100] = 32'h11111111; mem[0] = enc(4, 1, 100, 14'h2ABC);
        run_prog(5, 14'd1, 1, "R12");
        chk("R7", "copy immediate", rd(100), 32'h2ABC);

        // R8 load-indirect, pointer truncated
        mem.delete();
        mem[200] = 32'hFFFFC000 | 32'd300; mem[300] = 32'h5A5A1234; mem[0] = enc(5, 0, 100, 200);
        run_prog(6, 14'd1, 1, "R13");
        chk("R8", "load indirect value", rd(100), 32'h5A5A1234);
        mem.delete();
        mem[200] = 32'd77; mem[77] = 32'h01020304; mem[0] = enc(5, 0, 100, 200);
        run_prog(6, 14'd1, 1, "R13");
        chk("R8", "load indirect small pointer", rd(100), 32'h01020304);

        // R9 store-indirect, pointer truncated, mem[A] untouched
        mem.delete();
        mem[100] = 32'hABCDC000 | 32'd400; mem[200] = 32'h0BADCAFE; mem[0] = enc(5, 1, 100, 200);
        run_prog(5, 14'd1, 1, "R12");
        chk("R9", "store indirect target", rd(400), 32'h0BADCAFE);
        chk("R9", "pointer word unchanged", rd(100), 32'hABCDC000 | 32'd400);

        // R10 branch on zero
        mem.delete();
        mem[100] = 32'h00007777; mem[200] = 32'h0; mem[0] = enc(6, 0, 100, 200);
        run_prog(5, 14'h3777, 0, "R10");
        chk("R10", "taken branch leaves operand", rd(100), 32'h00007777);
        mem.delete();
        mem[100] = 32'h00000050; mem[200] = 32'h100; mem[0] = enc(6, 0, 100, 200);
        run_prog(5, 14'd1, 0, "R10");

        // R11 jump
        mem.delete();
        mem[100] = 32'h3FFF; mem[0] = enc(6, 1, 100, 5);
        run_prog(5, 14'd4, 0, "R11");
        mem.delete();
        mem[100] = 32'd10; mem[0] = enc(6, 1, 100, 20);
        run_prog(5, 14'd30, 0, "R11");

        // R12 PC wrap from the last address back to 0
        mem.delete();
        mem[100] = 32'h3FFF; mem[0] = enc(6, 1, 100, 0);
        mem[16383] = enc(0, 1, 101, 9); mem[101] = 32'd6;
        run_prog(10, 14'd0, 1, "R12");
        chk("R12", "instruction at last address ran", rd(101), 32'd15);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule